// File: doc/BRIEF.md
# Shadow Stack Instruction Classifier

This block sits in the decode stage of a processor front end. It examines one instruction word, either a full 32-bit word or a 16-bit compressed word held in the low half, together with a run-time flag that says whether shadow stacks are active at the current privilege level. It reports which shadow-stack operation the word asks for: push, pop-and-check, read of the shadow pointer, or atomic swap. Words taken from the reserved may-be-operation (MOP) space that select no active shadow-stack operation are reported as plain MOPs, which the execute stage turns into a write of zero to the destination register.

The block is purely combinational. It looks only at the MOP encoding space and the swap opcode. Every other word is reported as "not handled" and is left to the main decoder. A word is treated as compressed when bits [1:0] are not 2'b11. The width of the machine word (32 or 64) and the presence of the atomic extension are parameters.

Top module: `ssdec_top`

## Requirements
- R1: A word outside the MOP space and the swap opcode gives op_kind 0 (none), link_reg 0, dest_reg 0, swap_dword 0 and illegal 0. The op_kind codes are: 0 none, 1 plain MOP, 2 push, 3 pop-and-check, 4 read pointer, 5 swap.
- R2: A single-source MOP has opcode 7'b1110011, funct3 3'b100, bit31=1, bits[29:28]=0 and bits[25:22]=4'b0111. Its slot number is {bit30, bits[27:26], bits[21:20]}. When this slot number is 28, rd=0 and rs1 is 1 or 5, and shadow stacks are active, the word is pop-and-check (op 3) with link_reg equal to rs1 and dest_reg 0.
- R3: In single-source slot 28 with rs1=0 and rd not 0, and shadow stacks active, the word is read-pointer (op 4) with dest_reg equal to rd and link_reg 0.
- R4: A two-source MOP has opcode 7'b1110011, funct3 3'b100, bit31=1, bits[29:28]=0 and bit25=1. Its slot number is {bit30, bits[27:26]}. In slot 7 with rd=0, rs1=0 and rs2 equal to 1 or 5, and shadow stacks active, the word is push (op 2) with link_reg equal to rs2 and dest_reg 0.
- R5: Any other 32-bit MOP word, in any slot and with any register fields, is a plain MOP (op 1) with dest_reg equal to rd, link_reg 0 and illegal 0.
- R6: A compressed MOP has bits[1:0]=01, bits[15:13]=011, bit12=0, bits[6:2]=0 and a register field in bits[11:7] with (field & 5'b10001)==1. With shadow stacks active, field 1 gives push (op 2, link_reg 1) and field 5 gives pop-and-check (op 3, link_reg 5). Every other such field gives a plain MOP. dest_reg is 0 for every compressed result.
- R7: A compressed word in the same quadrant and funct3 whose immediate bits are not all zero, or whose register field fails the mask test, gives op 0.
- R8: When shadow stacks are not active, the push, pop-and-check and read-pointer code points (32-bit and compressed) give a plain MOP with the dest_reg of R5 or R6.
- R9: The swap word has opcode 7'b0101111 and bits[31:27]=5'b01001. With funct3 3'b010 (word form), shadow stacks active and the atomic extension present, it gives op 5, dest_reg equal to rd, swap_dword 0 and illegal 0.
- R10: The swap with funct3 3'b011 (doubleword form) gives op 5 with swap_dword 1 when XLEN is 64. When XLEN is 32 it gives illegal 1 and op 0.
- R11: Either swap form gives illegal 1 and op 0 when shadow stacks are not active.
- R12: Either swap form gives illegal 1 and op 0 when the atomic extension is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word; a compressed word sits in bits [15:0] |
| ss_active | input | 1 | Shadow stacks are active at the current privilege |
| op_kind | output | 3 | Operation code (see R1) |
| link_reg | output | 5 | Return-address register checked or pushed (1 or 5), else 0 |
| dest_reg | output | 5 | Destination register index |
| swap_dword | output | 1 | Swap operates on a doubleword |
| illegal | output | 1 | Swap word is not allowed in the present configuration |

## Verification
The bench builds three copies of the block side by side and drives them with the same inputs. The first copy uses XLEN=64 with atomics present and carries most checks. The second uses XLEN=32, so the doubleword swap becomes illegal. The third has no atomic extension, so even an active word-form swap is refused. Because of these three builds, every branch of the swap legality gate can be reached without rebuilding the bench.

// File: rtl/ssdec_pkg.sv
package ssdec_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MOP    = 3'd1,
        OP_PUSH   = 3'd2,
        OP_POPCHK = 3'd3,
        OP_RDSSP  = 3'd4,
        OP_SWAP   = 3'd5
    } ss_op_e;

    typedef struct packed {
        ss_op_e     op;
        logic [4:0] link;
        logic [4:0] dest;
        logic       wide;
        logic       illegal;
    } ss_dec_t;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
    localparam logic [6:0] OPC_AMO    = 7'b0101111;
    localparam logic [2:0] F3_MOP     = 3'b100;
    localparam logic [4:0] F5_SSSWAP  = 5'b01001;
    localparam logic [2:0] F3_WORD    = 3'b010;
    localparam logic [2:0] F3_DWORD   = 3'b011;
    localparam logic [4:0] REG_RA     = 5'd1;
    localparam logic [4:0] REG_ALT    = 5'd5;

    localparam ss_dec_t DEC_EMPTY = '{op: OP_NONE, link: 5'd0, dest: 5'd0,
                                      wide: 1'b0, illegal: 1'b0};

endpackage

// File: rtl/ssdec_wide.sv
module ssdec_wide
    import ssdec_pkg::*;
#(
    parameter int R_SLOT  = 28,
    parameter int RR_SLOT = 7
) (
    input  logic [31:0] instr,
    input  logic        ss_active,
    output ss_dec_t     res
);
    localparam logic [4:0] R_ID  = 5'(R_SLOT);
    localparam logic [2:0] RR_ID = 3'(RR_SLOT);

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_R,
        FORM_RR
    } mop_form_e;

    logic [4:0] rd, rs1, rs2;
    logic [4:0] slot_r;
    logic [2:0] slot_rr;
    logic       sys_mop;
    logic       link_rs1, link_rs2;
    mop_form_e  form;

    assign rd      = instr[11:7];
    assign rs1     = instr[19:15];
    assign rs2     = instr[24:20];
    assign slot_r  = {instr[30], instr[27:26], instr[21:20]};
    assign slot_rr = {instr[30], instr[27:26]};
    assign sys_mop = (instr[6:0] == OPC_SYSTEM) && (instr[14:12] == F3_MOP)
                   && instr[31] && (instr[29:28] == 2'b00);

    assign link_rs1 = (rs1 == REG_RA) || (rs1 == REG_ALT);
    assign link_rs2 = (rs2 == REG_RA) || (rs2 == REG_ALT);

    always_comb begin
        form = FORM_NONE;
        if (sys_mop && instr[25])
            form = FORM_RR;
        else if (sys_mop && (instr[25:22] == 4'b0111))
            form = FORM_R;
    end

    always_comb begin
        res = DEC_EMPTY;
        unique case (form)
            FORM_R: begin
                res.op   = OP_MOP;
                res.dest = rd;
                if (ss_active && (slot_r == R_ID)) begin
                    if ((rd == 5'd0) && link_rs1) begin
                        res.op   = OP_POPCHK;
                        res.link = rs1;
                        res.dest = 5'd0;
                    end else if ((rs1 == 5'd0) && (rd != 5'd0)) begin
                        res.op   = OP_RDSSP;
                    end
                end
            end
            FORM_RR: begin
                res.op   = OP_MOP;
                res.dest = rd;
                if (ss_active && (slot_rr == RR_ID) && (rd == 5'd0)
                    && (rs1 == 5'd0) && link_rs2) begin
                    res.op   = OP_PUSH;
                    res.link = rs2;
                end
            end
            default: res = DEC_EMPTY;
        endcase
    end
endmodule

// File: rtl/ssdec_narrow.sv
module ssdec_narrow
    import ssdec_pkg::*;
(
    input  logic [15:0] instr,
    input  logic        ss_active,
    output ss_dec_t     res
);
    logic [4:0] field;
    logic       cmop;

    assign field = instr[11:7];
    assign cmop  = (instr[1:0] == 2'b01) && (instr[15:13] == 3'b011)
                 && !instr[12] && (instr[6:2] == 5'd0)
                 && ((field & 5'b10001) == 5'b00001);

    always_comb begin
        res = DEC_EMPTY;
        if (cmop) begin
            res.op = OP_MOP;
            if (ss_active && (field == REG_RA)) begin
                res.op   = OP_PUSH;
                res.link = REG_RA;
            end else if (ss_active && (field == REG_ALT)) begin
                res.op   = OP_POPCHK;
                res.link = REG_ALT;
            end
        end
    end
endmodule

// File: rtl/ssdec_swap.sv
module ssdec_swap
    import ssdec_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit HAS_ATOMIC = 1'b1
) (
    input  logic [6:0] opcode,
    input  logic [4:0] funct5,
    input  logic [2:0] funct3,
    input  logic [4:0] rd,
    input  logic       ss_active,
    output ss_dec_t    res
);
    logic is_word, is_dword, hit, size_ok;

    assign hit      = (opcode == OPC_AMO) && (funct5 == F5_SSSWAP);
    assign is_word  = hit && (funct3 == F3_WORD);
    assign is_dword = hit && (funct3 == F3_DWORD);

    generate
        if (XLEN == 64) begin : g_x64
            assign size_ok = is_word || is_dword;
        end else begin : g_x32
            assign size_ok = is_word;
        end
    endgenerate

    always_comb begin
        res = DEC_EMPTY;
        if (is_word || is_dword) begin
            if (HAS_ATOMIC && ss_active && size_ok) begin
                res.op   = OP_SWAP;
                res.dest = rd;
                res.wide = is_dword;
            end else begin
                res.illegal = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssdec_top.sv
module ssdec_top
    import ssdec_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit HAS_ATOMIC = 1'b1,
    parameter int R_SLOT     = 28,
    parameter int RR_SLOT    = 7
) (
    input  logic [31:0] instr,
    input  logic        ss_active,
    output logic [2:0]  op_kind,
    output logic [4:0]  link_reg,
    output logic [4:0]  dest_reg,
    output logic        swap_dword,
    output logic        illegal
);
    typedef enum logic [1:0] {
        SRC_NARROW,
        SRC_WIDE,
        SRC_SWAP
    } src_e;

    ss_dec_t res_wide, res_narrow, res_swap, res_sel;
    src_e    src;

    ssdec_wide #(.R_SLOT(R_SLOT), .RR_SLOT(RR_SLOT)) u_wide (
        .instr     (instr),
        .ss_active (ss_active),
        .res       (res_wide)
    );

    ssdec_narrow u_narrow (
        .instr     (instr[15:0]),
        .ss_active (ss_active),
        .res       (res_narrow)
    );

    ssdec_swap #(.XLEN(XLEN), .HAS_ATOMIC(HAS_ATOMIC)) u_swap (
        .opcode    (instr[6:0]),
        .funct5    (instr[31:27]),
        .funct3    (instr[14:12]),
        .rd        (instr[11:7]),
        .ss_active (ss_active),
        .res       (res_swap)
    );

    always_comb begin
        if (instr[1:0] != 2'b11)
            src = SRC_NARROW;
        else if (res_wide.op != OP_NONE)
            src = SRC_WIDE;
        else
            src = SRC_SWAP;
    end

    always_comb begin
        unique case (src)
            SRC_NARROW: res_sel = res_narrow;
            SRC_WIDE:   res_sel = res_wide;
            SRC_SWAP:   res_sel = res_swap;
            default:    res_sel = DEC_EMPTY;
        endcase
    end

    assign op_kind    = res_sel.op;
    assign link_reg   = res_sel.link;
    assign dest_reg   = res_sel.dest;
    assign swap_dword = res_sel.wide;
    assign illegal    = res_sel.illegal;
endmodule

// File: rtl/ssdec_chk.sv
module ssdec_chk
    import ssdec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic       ss_active,
    input logic [2:0] op_kind,
    input logic [4:0] link_reg,
    input logic [4:0] dest_reg,
    input logic       swap_dword,
    input logic       illegal
);
    always_comb begin
        AST_ILLEGAL_NO_OP: assert (!illegal || (op_kind == OP_NONE))
            else $error("illegal word carries an operation"); // R11
        AST_LINK_REG_VALID: assert (!((op_kind == OP_PUSH) || (op_kind == OP_POPCHK))
                                    || (link_reg == 5'd1) || (link_reg == 5'd5))
            else $error("link register not x1 or x5"); // R2
        AST_INACTIVE_NO_SS: assert (ss_active || !((op_kind == OP_PUSH) || (op_kind == OP_POPCHK)
                                    || (op_kind == OP_RDSSP) || (op_kind == OP_SWAP)))
            else $error("shadow-stack op while inactive"); // R8
        AST_RDSSP_DEST: assert ((op_kind != OP_RDSSP) || (dest_reg != 5'd0))
            else $error("read pointer to x0"); // R3
        AST_DWORD_XLEN: assert (!swap_dword || ((XLEN == 64) && (op_kind == OP_SWAP)))
            else $error("doubleword swap not allowed"); // R10
        AST_PUSH_NO_DEST: assert (!((op_kind == OP_PUSH) || (op_kind == OP_POPCHK))
                                  || (dest_reg == 5'd0))
            else $error("push or pop writes a register"); // R4
    end
endmodule

bind ssdec_top ssdec_chk #(.XLEN(XLEN)) u_chk (
    .ss_active  (ss_active),
    .op_kind    (op_kind),
    .link_reg   (link_reg),
    .dest_reg   (dest_reg),
    .swap_dword (swap_dword),
    .illegal    (illegal)
);

// File: tb/ssdec_top_bench.sv
module ssdec_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'd0;
    logic        ss_active = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic [2:0] op_a, op_b, op_c;
    logic [4:0] lk_a, lk_b, lk_c, rd_a, rd_b, rd_c;
    logic       dw_a, dw_b, dw_c, il_a, il_b, il_c;

    always #2.5 clk = ~clk;

    ssdec_top #(.XLEN(64), .HAS_ATOMIC(1'b1)) u_ssdec_top (
        .instr(instr), .ss_active(ss_active), .op_kind(op_a), .link_reg(lk_a),
        .dest_reg(rd_a), .swap_dword(dw_a), .illegal(il_a));
    ssdec_top #(.XLEN(32), .HAS_ATOMIC(1'b1)) u_ssdec_top_x32 (
        .instr(instr), .ss_active(ss_active), .op_kind(op_b), .link_reg(lk_b),
        .dest_reg(rd_b), .swap_dword(dw_b), .illegal(il_b));
    ssdec_top #(.XLEN(64), .HAS_ATOMIC(1'b0)) u_ssdec_top_noamo (
        .instr(instr), .ss_active(ss_active), .op_kind(op_c), .link_reg(lk_c),
        .dest_reg(rd_c), .swap_dword(dw_c), .illegal(il_c));

    function automatic logic [31:0] mop_r(logic [4:0] n, logic [4:0] rs1, logic [4:0] rd);
        return {1'b1, n[4], 2'b00, n[3:2], 4'b0111, n[1:0], rs1, 3'b100, rd, 7'b1110011};
    endfunction
    function automatic logic [31:0] mop_rr(logic [2:0] n, logic [4:0] rs2, logic [4:0] rs1,
                                           logic [4:0] rd);
        return {1'b1, n[2], 2'b00, n[1:0], 1'b1, rs2, rs1, 3'b100, rd, 7'b1110011};
    endfunction
    function automatic logic [31:0] cmop(logic [4:0] fld, logic [4:0] imm);
        return {16'h0000, 3'b011, 1'b0, fld, imm, 2'b01};
    endfunction
    function automatic logic [31:0] sswap(logic [2:0] f3, logic [4:0] rd);
        return {5'b01001, 2'b00, 5'd2, 5'd3, f3, rd, 7'b0101111};
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] w, logic act);
        @(negedge clk);
        instr = w;
        ss_active = act;
        #1;
    endtask

    task automatic expect_a(string req, int op, int lk, int rd, int dw, int il);
        chk(req, "op", int'(op_a), op);
        chk(req, "link", int'(lk_a), lk);
        chk(req, "dest", int'(rd_a), rd);
        chk(req, "dword", int'(dw_a), dw);
        chk(req, "illegal", int'(il_a), il);
    endtask

    task automatic t_idle();
        apply(32'h0000_0013, 1'b1);          // R1 addi
        expect_a("R1", 0, 0, 0, 0, 0);
        apply(32'h0000_0000, 1'b1);          // R1 all-zero word
        expect_a("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_pop();
        apply(mop_r(5'd28, 5'd1, 5'd0), 1'b1);
        expect_a("R2", 3, 1, 0, 0, 0);
        apply(mop_r(5'd28, 5'd5, 5'd0), 1'b1);
        expect_a("R2", 3, 5, 0, 0, 0);
    endtask

    task automatic t_rdssp();
        apply(mop_r(5'd28, 5'd0, 5'd9), 1'b1);
        expect_a("R3", 4, 0, 9, 0, 0);
        apply(mop_r(5'd28, 5'd0, 5'd31), 1'b1);
        expect_a("R3", 4, 0, 31, 0, 0);
    endtask

    task automatic t_push();
        apply(mop_rr(3'd7, 5'd1, 5'd0, 5'd0), 1'b1);
        expect_a("R4", 2, 1, 0, 0, 0);
        apply(mop_rr(3'd7, 5'd5, 5'd0, 5'd0), 1'b1);
        expect_a("R4", 2, 5, 0, 0, 0);
    endtask

    task automatic t_other_mop();
        apply(mop_r(5'd28, 5'd2, 5'd0), 1'b1);     // rs1 not a link register
        expect_a("R5", 1, 0, 0, 0, 0);
        apply(mop_r(5'd28, 5'd1, 5'd4), 1'b1);     // rd and rs1 both nonzero
        expect_a("R5", 1, 0, 4, 0, 0);
        apply(mop_r(5'd27, 5'd1, 5'd0), 1'b1);     // wrong slot
        expect_a("R5", 1, 0, 0, 0, 0);
        apply(mop_rr(3'd7, 5'd1, 5'd3, 5'd0), 1'b1); // rs1 nonzero
        expect_a("R5", 1, 0, 0, 0, 0);
        apply(mop_rr(3'd7, 5'd1, 5'd0, 5'd6), 1'b1); // rd nonzero
        expect_a("R5", 1, 0, 6, 0, 0);
        apply(mop_rr(3'd6, 5'd5, 5'd0, 5'd0), 1'b1); // wrong slot
        expect_a("R5", 1, 0, 0, 0, 0);
    endtask

    task automatic t_compressed();
        apply(cmop(5'd1, 5'd0), 1'b1);
        expect_a("R6", 2, 1, 0, 0, 0);
        apply(cmop(5'd5, 5'd0), 1'b1);
        expect_a("R6", 3, 5, 0, 0, 0);
        apply(cmop(5'd3, 5'd0), 1'b1);
        expect_a("R6", 1, 0, 0, 0, 0);
        apply(cmop(5'd15, 5'd0), 1'b1);
        expect_a("R6", 1, 0, 0, 0, 0);
    endtask

    task automatic t_compressed_reject();
        apply(cmop(5'd1, 5'd4), 1'b1);      // immediate nonzero
        expect_a("R7", 0, 0, 0, 0, 0);
        apply(cmop(5'd17, 5'd0), 1'b1);     // mask test fails
        expect_a("R7", 0, 0, 0, 0, 0);
        apply(cmop(5'd2, 5'd0), 1'b1);      // even field
        expect_a("R7", 0, 0, 0, 0, 0);
    endtask

    task automatic t_inactive();
        apply(mop_r(5'd28, 5'd1, 5'd0), 1'b0);
        expect_a("R8", 1, 0, 0, 0, 0);
        apply(mop_r(5'd28, 5'd0, 5'd7), 1'b0);
        expect_a("R8", 1, 0, 7, 0, 0);
        apply(mop_rr(3'd7, 5'd5, 5'd0, 5'd0), 1'b0);
        expect_a("R8", 1, 0, 0, 0, 0);
        apply(cmop(5'd1, 5'd0), 1'b0);
        expect_a("R8", 1, 0, 0, 0, 0);
        apply(cmop(5'd5, 5'd0), 1'b0);
        expect_a("R8", 1, 0, 0, 0, 0);
    endtask

    task automatic t_swap_word();
        apply(sswap(3'b010, 5'd12), 1'b1);
        expect_a("R9", 5, 0, 12, 0, 0);
        chk("R9", "x32 op", int'(op_b), 5);
        chk("R9", "x32 illegal", int'(il_b), 0);
    endtask

    task automatic t_swap_dword();
        apply(sswap(3'b011, 5'd20), 1'b1);
        expect_a("R10", 5, 0, 20, 1, 0);
        chk("R10", "x32 op", int'(op_b), 0);
        chk("R10", "x32 illegal", int'(il_b), 1);
        chk("R10", "x32 dword", int'(dw_b), 0);
    endtask

    task automatic t_swap_inactive();
        apply(sswap(3'b010, 5'd12), 1'b0);
        expect_a("R11", 0, 0, 0, 0, 1);
        apply(sswap(3'b011, 5'd12), 1'b0);
        expect_a("R11", 0, 0, 0, 0, 1);
    endtask

    task automatic t_no_atomic();
        apply(sswap(3'b010, 5'd8), 1'b1);
        chk("R12", "noamo op", int'(op_c), 0);
        chk("R12", "noamo illegal", int'(il_c), 1);
        apply(sswap(3'b011, 5'd8), 1'b1);
        chk("R12", "noamo op", int'(op_c), 0);
        chk("R12", "noamo illegal", int'(il_c), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        expect_a("R1", 0, 0, 0, 0, 0);      // quiet inputs out of reset
        t_idle();
        t_pop();
        t_rdssp();
        t_push();
        t_other_mop();
        t_compressed();
        t_compressed_reject();
        t_inactive();
        t_swap_word();
        t_swap_dword();
        t_swap_inactive();
        t_no_atomic();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule